// File: doc/BRIEF.md
# Shared Interrupt Router with Pin Vector Encoding

This block gathers a parameterised number of external interrupt lines and presents them to a processor as six prioritised interrupt pins, a non-maskable output and one further special output. Software configures it over a plain 32-bit register bus with a combinational read path. For every source it holds four settings: active sense, whether the source is edge or level sensitive, whether both edges count, and whether the source is enabled. Each source also has a route word that chooses its destination.

Every input passes through a two-flop synchroniser. A level source is pending while its synchronised input equals its active sense. An edge source latches a pending flag when the chosen transition occurs, and software clears that flag with a single injection write. The same write can also raise the flag. A source that is both pending and enabled drives the output its route word selects. An encoded vector reports the highest active pin plus one, and zero means that no pin is active.

Top module: `irqShareCtl`

## Requirements
- R1: Asynchronous active-low reset clears the sense, trigger, dual, enable and route registers, so every output is low and the vector reads 0 after reset. While reset holds, a level source with sense 0 and a low input shows as pending.
- R2: The sense, trigger and dual banks sit at byte addresses 0x000, 0x040 and 0x080 plus 4*w. Word w holds sources 32w to 32w+31, and source n is bit n%32. Writes are read back on the implemented bits. Bits and words that are not implemented read 0 and do not disturb the other words.
- R3: Writing 1 to a bit of the set bank (0x0C0+4w) enables that source. Writing 1 to a bit of the clear bank (0x100+4w) disables it. A 0 bit has no effect. The enable view at 0x140+4w is read-only, with 1 meaning enabled. A write to the view changes nothing.
- R4: A source with trigger bit 0 is pending exactly while its synchronised input equals its sense bit, where 1 means active-high and 0 means active-low. A change on the input shows up in the pending view after two clock edges.
- R5: A source with trigger bit 1 and dual bit 0 latches pending on a rising edge when its sense bit is 1, or on a falling edge when its sense bit is 0. It stays pending after the input returns, until software clears it.
- R6: A source with trigger bit 1 and dual bit 1 latches pending on both rising and falling edges.
- R7: The injection register at 0x1C0 takes the source number in bits [7:0]. Bit 31 set to 1 raises that source's edge flag and bit 31 set to 0 clears it. Bits [30:8] are ignored, and a number of a source that does not exist changes nothing.
- R8: The route word of source n at 0x400+4n keeps bit 31 (to a pin), bit 30 (to the non-maskable output), bit 29 (to the special output) and bits [5:0] (pin number). Other bits read 0. A source drives its destinations only while it is pending and enabled, and a pin number of 6 or more drives no pin.
- R9: vecOut is 0 when no pin is active. Otherwise it is one plus the highest active pin number.
- R10: The pending view at 0x180+4w is read-only. For an edge source it shows the latched flag and for a level source it shows the live level state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Asynchronous interrupt inputs |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 12 | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinOut | output | NUM_PINS | Interrupt pins |
| nmiOut | output | 1 | Non-maskable interrupt output |
| specOut | output | 1 | Special interrupt output |
| vecOut | output | clog2(NUM_PINS+1) | Highest active pin plus one, 0 if none |

## Verification
The bench checks the two-edge latency of the synchroniser at its exact cycle. A design with one stage too many or too few shows the level change early or late. It checks that an edge flag survives the input returning to idle and that the falling edge counts under sense 0. A design that recomputes edge pending from the live level, or that ignores the sense bit on edges, loses the event or catches the wrong one. It also checks a disabled pending source, a pin number out of range, a route word with bit 31 clear, and two pins active together. A router that skips the enable or the bit 31 gate drives a pin it must not. An encoder that favours the lowest pin reports the wrong vector.

// File: rtl/irqShare_pkg.sv
package irqShare_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_IDX_W = 4;
  localparam int MAP_IDX_W = 8;

  typedef enum logic [2:0] {
    RD_NONE, RD_POL, RD_TRIG, RD_DUAL, RD_EN, RD_PEND, RD_MAP
  } rdSel_e;

  typedef struct packed {
    logic wrPol;
    logic wrTrig;
    logic wrDual;
    logic wrEnSet;
    logic wrEnClr;
    logic wrInject;
    logic wrMap;
    rdSel_e rdSel;
    logic [WORD_IDX_W-1:0] word;
    logic [MAP_IDX_W-1:0] mapIdx;
  } ctlStrobe_t;

  typedef struct packed {
    logic toPin;
    logic toNmi;
    logic toSpec;
    logic [5:0] pinSel;
  } routeMap_t;
endpackage

// File: rtl/irqShare_ctrl.sv
module irqShare_ctrl
  import irqShare_pkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        ctl
);
  logic aligned;
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    ctl = '0;
    ctl.rdSel = RD_NONE;
    ctl.word = busAddr[5:2];
    ctl.mapIdx = busAddr[9:2];
    if (aligned) begin
      case (busAddr[11:10])
        2'b00: begin
          case (busAddr[9:6])
            4'd0: begin ctl.wrPol = busWe; ctl.rdSel = RD_POL; end
            4'd1: begin ctl.wrTrig = busWe; ctl.rdSel = RD_TRIG; end
            4'd2: begin ctl.wrDual = busWe; ctl.rdSel = RD_DUAL; end
            4'd3: ctl.wrEnSet = busWe;
            4'd4: ctl.wrEnClr = busWe;
            4'd5: ctl.rdSel = RD_EN;
            4'd6: ctl.rdSel = RD_PEND;
            4'd7: ctl.wrInject = busWe && (busAddr[5:2] == 4'd0);
            default: ;
          endcase
        end
        2'b01: begin
          ctl.wrMap = busWe;
          ctl.rdSel = RD_MAP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqShare_dp.sv
module irqShare_dp
  import irqShare_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_PINS = 6,
  parameter int VEC_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  ctlStrobe_t          ctl,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic                nmiOut,
  output logic                specOut,
  output logic [VEC_W-1:0]    vecOut
);
  localparam int NWORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W = NWORDS * 32;

  logic [NUM_SRC-1:0] syncA, syncB, prevB;
  logic [NUM_SRC-1:0] polBank, trigBank, dualBank, enBank, pendView, activeSrc;
  routeMap_t mapArr [NUM_SRC];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam logic [WORD_IDX_W-1:0] W = WORD_IDX_W'(n / 32);
    localparam int B = n % 32;
    logic polQ, trigQ, dualQ, enQ, pendQ;
    routeMap_t mapQ;
    logic hit, injHit, rise, fall, evt;

    assign hit = (ctl.word == W);
    assign injHit = ctl.wrInject && (busWdata[7:0] == 8'(n));
    assign rise = syncB[n] & ~prevB[n];
    assign fall = ~syncB[n] & prevB[n];
    assign evt = trigQ & (dualQ ? (rise | fall) : (polQ ? rise : fall));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        polQ <= 1'b0;
        trigQ <= 1'b0;
        dualQ <= 1'b0;
        enQ <= 1'b0;
        pendQ <= 1'b0;
        mapQ <= '0;
      end else begin
        if (ctl.wrPol && hit) polQ <= busWdata[B];
        if (ctl.wrTrig && hit) trigQ <= busWdata[B];
        if (ctl.wrDual && hit) dualQ <= busWdata[B];
        if (ctl.wrEnSet && hit && busWdata[B]) enQ <= 1'b1;
        else if (ctl.wrEnClr && hit && busWdata[B]) enQ <= 1'b0;
        if (injHit) pendQ <= busWdata[31];
        else if (evt) pendQ <= 1'b1;
        if (ctl.wrMap && (ctl.mapIdx == 8'(n)))
          mapQ <= '{busWdata[31], busWdata[30], busWdata[29], busWdata[5:0]};
      end
    end

    assign polBank[n] = polQ;
    assign trigBank[n] = trigQ;
    assign dualBank[n] = dualQ;
    assign enBank[n] = enQ;
    assign pendView[n] = trigQ ? pendQ : (syncB[n] == polQ);
    assign activeSrc[n] = pendView[n] & enQ;
    assign mapArr[n] = mapQ;
  end

  // routing of active sources onto the outputs
  always_comb begin
    pinOut = '0;
    nmiOut = 1'b0;
    specOut = 1'b0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (activeSrc[n]) begin
        if (mapArr[n].toPin)
          for (int p = 0; p < NUM_PINS; p++)
            if (mapArr[n].pinSel == 6'(p)) pinOut[p] = 1'b1;
        nmiOut = nmiOut | mapArr[n].toNmi;
        specOut = specOut | mapArr[n].toSpec;
      end
    end
  end

  // highest active pin wins
  always_comb begin
    vecOut = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (pinOut[p]) vecOut = VEC_W'(p + 1);
  end

  function automatic logic [31:0] pickWord(input logic [PAD_W-1:0] v,
                                           input logic [WORD_IDX_W-1:0] w);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < NWORDS; k++)
      if (int'(w) == k) r = v[k*32 +: 32];
    return r;
  endfunction

  always_comb begin
    busRdata = '0;
    case (ctl.rdSel)
      RD_POL:  busRdata = pickWord(PAD_W'(polBank), ctl.word);
      RD_TRIG: busRdata = pickWord(PAD_W'(trigBank), ctl.word);
      RD_DUAL: busRdata = pickWord(PAD_W'(dualBank), ctl.word);
      RD_EN:   busRdata = pickWord(PAD_W'(enBank), ctl.word);
      RD_PEND: busRdata = pickWord(PAD_W'(pendView), ctl.word);
      RD_MAP: begin
        for (int n = 0; n < NUM_SRC; n++)
          if (ctl.mapIdx == 8'(n))
            busRdata = {mapArr[n].toPin, mapArr[n].toNmi, mapArr[n].toSpec,
                        23'd0, mapArr[n].pinSel};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irqShareCtl.sv
module irqShareCtl
  import irqShare_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_PINS = 6,
  localparam int VEC_W = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic                nmiOut,
  output logic                specOut,
  output logic [VEC_W-1:0]    vecOut
);
  ctlStrobe_t ctl;

  irqShare_ctrl ctrl_i (
    .busWe(busWe),
    .busAddr(busAddr),
    .ctl(ctl)
  );

  irqShare_dp #(
    .NUM_SRC(NUM_SRC),
    .NUM_PINS(NUM_PINS),
    .VEC_W(VEC_W)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .srcIn(srcIn),
    .ctl(ctl),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .pinOut(pinOut),
    .nmiOut(nmiOut),
    .specOut(specOut),
    .vecOut(vecOut)
  );
endmodule

// File: rtl/irqShareCtl_chk.sv
module irqShareCtl_chk #(
  parameter int NUM_PINS = 6,
  parameter int VEC_W = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWe,
  input logic [11:0]         busAddr,
  input logic [31:0]         busRdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic                nmiOut,
  input logic                specOut,
  input logic [VEC_W-1:0]    vecOut
);
  // R9
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut == '0) == (pinOut == '0));

  // R9
  vec_highest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut != '0) |-> ((pinOut >> (vecOut - 1'b1)) == NUM_PINS'(1)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOut == '0 && !nmiOut && !specOut && vecOut == '0));

  // R3
  en_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 12'h140) |=> (busAddr != 12'h140 || $stable(busRdata)));
endmodule

bind irqShareCtl irqShareCtl_chk #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) chk_i (
  .clk(clk),
  .rstN(rstN),
  .busWe(busWe),
  .busAddr(busAddr),
  .busRdata(busRdata),
  .pinOut(pinOut),
  .nmiOut(nmiOut),
  .specOut(specOut),
  .vecOut(vecOut)
);

// File: tb/irqShareCtl_tb_top.sv
module irqShareCtl_tb_top;
  localparam int NS = 40;
  localparam logic [11:0] A_POL = 12'h000, A_TRIG = 12'h040, A_DUAL = 12'h080,
    A_ENS = 12'h0C0, A_ENC = 12'h100, A_EN = 12'h140, A_PEND = 12'h180,
    A_INJ = 12'h1C0, A_MAP = 12'h400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] srcIn = '0;
  logic busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [5:0] pinOut;
  logic nmiOut, specOut;
  logic [2:0] vecOut;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  irqShareCtl #(.NUM_SRC(NS), .NUM_PINS(6)) dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinOut(pinOut),
    .nmiOut(nmiOut), .specOut(specOut), .vecOut(vecOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busWe = 1'b0;
    srcIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(input string tag, input logic [5:0] pins, input logic [2:0] vec,
                          input logic nmi, input logic spec);
    #1;
    check({tag, " pins"}, 32'(pinOut), 32'(pins));
    check({tag, " vec"}, 32'(vecOut), 32'(vec));
    check({tag, " nmi"}, 32'(nmiOut), 32'(nmi));
    check({tag, " spec"}, 32'(specOut), 32'(spec));
  endtask

  task automatic t_reset();
    doReset();
    rd(A_POL, rv);  check("R1 sense", rv, 32'h0);
    rd(A_TRIG, rv); check("R1 trig", rv, 32'h0);
    rd(A_EN, rv);   check("R1 enable", rv, 32'h0);
    rd(A_MAP, rv);  check("R1 route", rv, 32'h0);
    rd(A_PEND, rv); check("R1 pend w0", rv, 32'hFFFFFFFF);
    rd(A_PEND + 12'h4, rv); check("R1 pend w1", rv, 32'h000000FF);
    checkOut("R1 outputs", 6'h0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_banks();
    doReset();
    wr(A_POL + 12'h4, 32'hFFFFFFA5);
    rd(A_POL + 12'h4, rv); check("R2 sense w1", rv, 32'h000000A5);
    rd(A_POL, rv); check("R2 sense w0 untouched", rv, 32'h0);
    wr(A_TRIG, 32'h12345678);
    rd(A_TRIG, rv); check("R2 trig w0", rv, 32'h12345678);
    wr(A_DUAL + 12'h4, 32'h3C);
    rd(A_DUAL + 12'h4, rv); check("R2 dual w1", rv, 32'h3C);
    wr(A_POL + 12'h8, 32'hFFFFFFFF);
    rd(A_POL + 12'h8, rv); check("R2 missing word", rv, 32'h0);
    rd(A_POL + 12'h4, rv); check("R2 w1 after missing word", rv, 32'h000000A5);
  endtask

  task automatic t_enable();
    doReset();
    wr(A_ENS, 32'hF0); rd(A_EN, rv); check("R3 set", rv, 32'hF0);
    wr(A_ENS, 32'h03); rd(A_EN, rv); check("R3 set keeps", rv, 32'hF3);
    wr(A_ENC, 32'h30); rd(A_EN, rv); check("R3 clear", rv, 32'hC3);
    wr(A_ENC, 32'h00); rd(A_EN, rv); check("R3 zero clear", rv, 32'hC3);
    wr(A_EN, 32'hFFFFFFFF); rd(A_EN, rv); check("R3 view read-only", rv, 32'hC3);
    wr(A_ENS + 12'h4, 32'h81); rd(A_EN + 12'h4, rv); check("R3 set w1", rv, 32'h81);
  endtask

  task automatic t_level();
    doReset();
    wr(A_POL, 32'h8);
    rd(A_PEND, rv); check("R4 idle high-active", 32'(rv[3]), 32'd0);
    @(negedge clk); srcIn[3] = 1'b1;
    @(negedge clk); rd(A_PEND, rv); check("R4 one edge no change", 32'(rv[3]), 32'd0);
    @(negedge clk); rd(A_PEND, rv); check("R4 two edges visible", 32'(rv[3]), 32'd1);
    srcIn[3] = 1'b0; waitCyc(3);
    rd(A_PEND, rv); check("R4 follows low", 32'(rv[3]), 32'd0);
    srcIn[4] = 1'b1; waitCyc(3);
    rd(A_PEND, rv); check("R4 low-active released", 32'(rv[4]), 32'd0);
  endtask

  task automatic t_edge();
    doReset();
    wr(A_TRIG, 32'h20); wr(A_POL, 32'h20);
    rd(A_PEND, rv); check("R5 no event yet", 32'(rv[5]), 32'd0);
    srcIn[5] = 1'b1; waitCyc(4);
    rd(A_PEND, rv); check("R5 rising latched", 32'(rv[5]), 32'd1);
    srcIn[5] = 1'b0; waitCyc(4);
    rd(A_PEND, rv); check("R5 held after idle", 32'(rv[5]), 32'd1);
    wr(A_INJ, 32'h5);
    rd(A_PEND, rv); check("R5 cleared", 32'(rv[5]), 32'd0);
    wr(A_POL, 32'h0);
    srcIn[5] = 1'b1; waitCyc(4);
    rd(A_PEND, rv); check("R5 falling mode ignores rise", 32'(rv[5]), 32'd0);
    srcIn[5] = 1'b0; waitCyc(4);
    rd(A_PEND, rv); check("R5 falling latched", 32'(rv[5]), 32'd1);
  endtask

  task automatic t_dual();
    doReset();
    wr(A_TRIG, 32'h40); wr(A_DUAL, 32'h40); wr(A_POL, 32'h40);
    srcIn[6] = 1'b1; waitCyc(4);
    rd(A_PEND, rv); check("R6 rise", 32'(rv[6]), 32'd1);
    wr(A_INJ, 32'h6);
    rd(A_PEND, rv); check("R6 cleared", 32'(rv[6]), 32'd0);
    srcIn[6] = 1'b0; waitCyc(4);
    rd(A_PEND, rv); check("R6 fall", 32'(rv[6]), 32'd1);
  endtask

  task automatic t_inject();
    doReset();
    wr(A_TRIG + 12'h4, 32'h2);
    rd(A_PEND + 12'h4, rv); check("R7 start", rv, 32'hFD);
    wr(A_INJ, 32'h80000021);
    rd(A_PEND + 12'h4, rv); check("R7 set", rv, 32'hFF);
    wr(A_INJ, 32'h00000021);
    rd(A_PEND + 12'h4, rv); check("R7 clear", rv, 32'hFD);
    wr(A_INJ, 32'h80FF0021);
    rd(A_PEND + 12'h4, rv); check("R7 middle bits ignored", rv, 32'hFF);
    wr(A_INJ, 32'h00000021);
    wr(A_INJ, 32'h80000050);
    rd(A_PEND + 12'h4, rv); check("R7 missing source w1", rv, 32'hFD);
    rd(A_PEND, rv); check("R7 missing source w0", rv, 32'hFFFFFFFF);
  endtask

  task automatic t_route();
    doReset();
    wr(A_TRIG + 12'h4, 32'h2);
    wr(A_INJ, 32'h80000021);
    wr(A_MAP + 12'h84, 32'h80000005);
    checkOut("R8 pending not enabled", 6'h0, 3'd0, 1'b0, 1'b0);
    wr(A_ENS + 12'h4, 32'h2);
    wr(A_MAP + 12'h84, 32'h40000000);
    checkOut("R8 to nmi", 6'h0, 3'd0, 1'b1, 1'b0);
    wr(A_MAP + 12'h84, 32'h20000000);
    checkOut("R8 to special", 6'h0, 3'd0, 1'b0, 1'b1);
    wr(A_MAP + 12'h84, 32'h80000007);
    checkOut("R8 pin out of range", 6'h0, 3'd0, 1'b0, 1'b0);
    wr(A_MAP + 12'h84, 32'h00000005);
    checkOut("R8 pin bit clear", 6'h0, 3'd0, 1'b0, 1'b0);
    wr(A_MAP + 12'h84, 32'h8000FF05);
    rd(A_MAP + 12'h84, rv); check("R8 route readback", rv, 32'h80000005);
    checkOut("R9 pin5", 6'h20, 3'd6, 1'b0, 1'b0);
    wr(A_POL, 32'h8);
    wr(A_MAP + 12'h0C, 32'h80000002);
    wr(A_ENS, 32'h8);
    srcIn[3] = 1'b1; waitCyc(3);
    checkOut("R9 two pins highest", 6'h24, 3'd6, 1'b0, 1'b0);
    wr(A_ENC + 12'h4, 32'h2);
    checkOut("R9 pin2 alone", 6'h04, 3'd3, 1'b0, 1'b0);
    wr(A_ENC, 32'h8);
    checkOut("R9 none", 6'h0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_pendRo();
    doReset();
    wr(A_PEND, 32'h0);
    rd(A_PEND, rv); check("R10 write ignored", rv, 32'hFFFFFFFF);
    wr(A_TRIG, 32'h1);
    rd(A_PEND, rv); check("R10 edge flag view", rv, 32'hFFFFFFFE);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_banks();
    t_enable();
    t_level();
    t_edge();
    t_dual();
    t_inject();
    t_route();
    t_pendRo();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule